// File: doc/BRIEF.md
# Qualified Bus Address Comparator

This block watches a CPU core bus and sends out a one-cycle match pulse when an access fits a programmed 17-bit address. It can also test two optional qualifiers: the direction of the access and whether it is a paged access. Software sets the compare address and the qualifier bits through a byte-wide register write port. Debug logic uses the pulse to start or stop tracing, or to break.

The address used for the compare depends on the kind of access. On a paged access it is the 3-bit page register value followed by the low 14 address bits. Otherwise it is the 16-bit CPU address with bit 16 held at zero. A page-select qualifier chooses which of the two kinds may match.

In full mode the comparator ignores its own direction, page and bit-16 qualifiers. It then compares only the raw 16-bit bus address. Direction qualification in that mode comes from a second comparator's enable and value bits, which arrive as inputs.

Top module: `bqc_top`

## Requirements
- R1: A match is evaluated only in a cycle with `bus_valid` high. `match_q` rises on the clock edge that samples the qualifying access and stays high for one cycle only, unless the next cycle also qualifies.
- R2: The low 16 compare bits come from two byte registers: offset 0x4 holds bits 15:8 and offset 0x5 holds bits 7:0. Each byte is written on its own and leaves the other byte unchanged.
- R3: Extension bit 7 is the direction enable and bit 6 is the direction value. When the enable is 0, `bus_rd` does not affect the match. When it is 1, `bus_rd` must equal the value bit (1 = read cycle, 0 = write cycle).
- R4: Extension bit 5 is page select. When it is 1, a match requires `bus_paged` = 1, and the 17-bit address compared is {`bus_page`[2:0], `bus_addr`[13:0]}.
- R5: When page select is 0, a match requires `bus_paged` = 0, and the 17-bit address compared is {0, `bus_addr`[15:0]}.
- R6: Extension bit 0 gives the required value of bit 16 of the compared address.
- R7: When `full_mode` = 1, extension bits 7, 6, 5 and 0 are ignored. `bus_addr`[15:0] is compared with the 16 compare bits, `bus_paged` and `bus_page` are ignored, and direction follows `alt_rw_en` and `alt_rw_val` with the same meaning as in R3.
- R8: `rst_n` low clears all registers. A `sys_rst` cycle always clears both compare bytes. It also clears the extension register, except when `dbg_on` = 1 and `trig_start` = 0, in which case the extension register keeps its contents.
- R9: The extension register is at offset 0x9. Writes to its bits 4 to 1 are ignored, and writes to other offsets do not change it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-up reset |
| sys_rst | input | 1 | Synchronous system reset request |
| dbg_on | input | 1 | Debug enable, used for extension retention |
| trig_start | input | 1 | Begin flag, used for extension retention |
| wr_en | input | 1 | Register write strobe |
| wr_ofs | input | 4 | Register write offset |
| wr_data | input | 8 | Register write data |
| bus_valid | input | 1 | Bus access valid this cycle |
| bus_addr | input | 16 | Core address |
| bus_paged | input | 1 | Access is a paged program access |
| bus_page | input | 3 | Page register value |
| bus_rd | input | 1 | 1 = read, 0 = write |
| full_mode | input | 1 | Full-mode select |
| alt_rw_en | input | 1 | Direction enable of the other comparator |
| alt_rw_val | input | 1 | Direction value of the other comparator |
| match_q | output | 1 | Registered match pulse |

## Verification
The block has no read-back path, so any wrong register content only shows up through `match_q`, one clock after an access that should or should not have matched. A corrupted compare byte or qualifier bit therefore shows as a missing or extra pulse on the first probe access that depends on that bit. For this reason each scenario probes the same address with the qualifier value on both sides of the boundary. The retention rule is checked by a reset request followed at once by a pair of probe accesses that differ only in the qualifier that was kept.

// File: rtl/bqc_pkg.sv
package bqc_pkg;
  localparam int unsigned BYTE_W   = 8;
  localparam int unsigned CADDR_W  = 16;
  localparam int unsigned PAGE_W   = 3;
  localparam int unsigned POFS_W   = 14;
  localparam int unsigned REGOFS_W = 4;

  localparam logic [REGOFS_W-1:0] OFS_CMP_HI = 4'h4;
  localparam logic [REGOFS_W-1:0] OFS_CMP_LO = 4'h5;
  localparam logic [REGOFS_W-1:0] OFS_EXT    = 4'h9;

  localparam int unsigned EXT_RWEN_BIT  = 7;
  localparam int unsigned EXT_RWVAL_BIT = 6;
  localparam int unsigned EXT_PGSEL_BIT = 5;
  localparam int unsigned EXT_HI_BIT    = 0;

  typedef struct packed {
    logic rw_en;
    logic rw_val;
    logic pg_sel;
    logic hi_bit;
  } ext_t;
endpackage

// File: rtl/bqc_regs.sv
module bqc_regs
  import bqc_pkg::*;
#(
  parameter int unsigned DW  = BYTE_W,
  parameter int unsigned OW  = REGOFS_W,
  parameter int unsigned NB  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sys_rst,
  input  logic             keep_ext,
  input  logic             wr_en,
  input  logic [OW-1:0]    wr_ofs,
  input  logic [DW-1:0]    wr_data,
  output logic [NB*DW-1:0] cmp_q,
  output ext_t             ext_q
);

  // Compare bytes: byte 0 is the low byte
  for (genvar gi = 0; gi < NB; gi++) begin : g_byte
    localparam logic [OW-1:0] MY_OFS = (gi == 0) ? OFS_CMP_LO : OFS_CMP_HI;
    logic          byte_ce;
    logic [DW-1:0] byte_d;
    logic [DW-1:0] byte_r;

    always_comb begin
      byte_ce = sys_rst | (wr_en & (wr_ofs == MY_OFS));
      byte_d  = sys_rst ? '0 : wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       byte_r <= '0;
      else if (byte_ce) byte_r <= byte_d;
    end

    assign cmp_q[gi*DW +: DW] = byte_r;
  end

  // Extension register: only four bits are stored
  logic ext_ce;
  ext_t ext_d;

  always_comb begin
    ext_ce = (sys_rst & ~keep_ext) | (~sys_rst & wr_en & (wr_ofs == OFS_EXT));
    if (sys_rst) begin
      ext_d = '0;
    end else begin
      ext_d.rw_en  = wr_data[EXT_RWEN_BIT];
      ext_d.rw_val = wr_data[EXT_RWVAL_BIT];
      ext_d.pg_sel = wr_data[EXT_PGSEL_BIT];
      ext_d.hi_bit = wr_data[EXT_HI_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ext_q <= '0;
    else if (ext_ce) ext_q <= ext_d;
  end

endmodule

// File: rtl/bqc_addr_form.sv
module bqc_addr_form
  import bqc_pkg::*;
#(
  parameter int unsigned AW = CADDR_W,
  parameter int unsigned PW = PAGE_W,
  parameter int unsigned FW = POFS_W,
  localparam int unsigned EW = AW + 1
) (
  input  logic [AW-1:0] addr,
  input  logic          paged,
  input  logic [PW-1:0] page,
  output logic [EW-1:0] eff_addr
);

  // Paged accesses form the address from page bits and the window offset
  always_comb begin
    if (paged) eff_addr = {page, addr[FW-1:0]};
    else       eff_addr = {1'b0, addr};
  end

endmodule

// File: rtl/bqc_qual.sv
module bqc_qual
  import bqc_pkg::*;
#(
  parameter int unsigned AW = CADDR_W,
  localparam int unsigned EW = AW + 1
) (
  input  logic [EW-1:0] eff_addr,
  input  logic [AW-1:0] raw_addr,
  input  logic [AW-1:0] cmp_addr,
  input  ext_t          ext,
  input  logic          paged,
  input  logic          rd,
  input  logic          full_mode,
  input  logic          alt_rw_en,
  input  logic          alt_rw_val,
  output logic          hit
);

  logic addr_ok;
  logic page_ok;
  logic dir_ok;
  logic dir_en;
  logic dir_val;

  always_comb begin
    if (full_mode) begin
      addr_ok = (raw_addr == cmp_addr);
      page_ok = 1'b1;
      dir_en  = alt_rw_en;
      dir_val = alt_rw_val;
    end else begin
      addr_ok = (eff_addr[AW-1:0] == cmp_addr) && (eff_addr[AW] == ext.hi_bit);
      page_ok = (paged == ext.pg_sel);
      dir_en  = ext.rw_en;
      dir_val = ext.rw_val;
    end
    dir_ok = ~dir_en | (rd == dir_val);
    hit    = addr_ok & page_ok & dir_ok;
  end

endmodule

// File: rtl/bqc_top.sv
module bqc_top
  import bqc_pkg::*;
#(
  parameter int unsigned DW = BYTE_W,
  parameter int unsigned AW = CADDR_W,
  parameter int unsigned PW = PAGE_W,
  parameter int unsigned FW = POFS_W,
  parameter int unsigned OW = REGOFS_W,
  localparam int unsigned NB = AW / DW,
  localparam int unsigned EW = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sys_rst,
  input  logic          dbg_on,
  input  logic          trig_start,
  input  logic          wr_en,
  input  logic [OW-1:0] wr_ofs,
  input  logic [DW-1:0] wr_data,
  input  logic          bus_valid,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_paged,
  input  logic [PW-1:0] bus_page,
  input  logic          bus_rd,
  input  logic          full_mode,
  input  logic          alt_rw_en,
  input  logic          alt_rw_val,
  output logic          match_q
);

  logic [AW-1:0] cmp_q;
  ext_t          ext_q;
  logic [EW-1:0] eff_addr;
  logic          hit;
  logic          keep_ext;
  logic          match_d;

  assign keep_ext = dbg_on & ~trig_start;

  bqc_regs #(.DW(DW), .OW(OW), .NB(NB)) i_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .sys_rst  (sys_rst),
    .keep_ext (keep_ext),
    .wr_en    (wr_en),
    .wr_ofs   (wr_ofs),
    .wr_data  (wr_data),
    .cmp_q    (cmp_q),
    .ext_q    (ext_q)
  );

  bqc_addr_form #(.AW(AW), .PW(PW), .FW(FW)) i_form (
    .addr     (bus_addr),
    .paged    (bus_paged),
    .page     (bus_page),
    .eff_addr (eff_addr)
  );

  bqc_qual #(.AW(AW)) i_qual (
    .eff_addr   (eff_addr),
    .raw_addr   (bus_addr),
    .cmp_addr   (cmp_q),
    .ext        (ext_q),
    .paged      (bus_paged),
    .rd         (bus_rd),
    .full_mode  (full_mode),
    .alt_rw_en  (alt_rw_en),
    .alt_rw_val (alt_rw_val),
    .hit        (hit)
  );

  always_comb begin
    match_d = bus_valid & hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) match_q <= 1'b0;
    else        match_q <= match_d;
  end

endmodule

// File: rtl/bqc_checker.sv
module bqc_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       sys_rst,
  input logic       dbg_on,
  input logic       trig_start,
  input logic       bus_valid,
  input logic       bus_paged,
  input logic       bus_rd,
  input logic       full_mode,
  input logic       alt_rw_en,
  input logic       alt_rw_val,
  input logic [3:0] ext_bits,
  input logic       match_q
);

  // ext_bits = {rw_en, rw_val, pg_sel, hi_bit}
  AST_IDLE_NO_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_valid |=> !match_q); // R1

  AST_DIR_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (!full_mode && ext_bits[3] && (ext_bits[2] != bus_rd)) |=> !match_q); // R3

  AST_PAGE_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (!full_mode && (ext_bits[1] != bus_paged)) |=> !match_q); // R4

  AST_ALT_DIR_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (full_mode && alt_rw_en && (alt_rw_val != bus_rd)) |=> !match_q); // R7

  AST_EXT_RETAINED: assert property (@(posedge clk) disable iff (!rst_n)
    (sys_rst && dbg_on && !trig_start) |=> $stable(ext_bits)); // R8

  AST_EXT_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    (sys_rst && !(dbg_on && !trig_start)) |=> (ext_bits == 4'b0000)); // R8

endmodule

bind bqc_top bqc_checker i_bqc_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .sys_rst    (sys_rst),
  .dbg_on     (dbg_on),
  .trig_start (trig_start),
  .bus_valid  (bus_valid),
  .bus_paged  (bus_paged),
  .bus_rd     (bus_rd),
  .full_mode  (full_mode),
  .alt_rw_en  (alt_rw_en),
  .alt_rw_val (alt_rw_val),
  .ext_bits   ({ext_q.rw_en, ext_q.rw_val, ext_q.pg_sel, ext_q.hi_bit}),
  .match_q    (match_q)
);

// File: tb/test_bqc_top.sv
module test_bqc_top;
  logic        clk;
  logic        rst_n;
  logic        sys_rst;
  logic        dbg_on;
  logic        trig_start;
  logic        wr_en;
  logic [3:0]  wr_ofs;
  logic [7:0]  wr_data;
  logic        bus_valid;
  logic [15:0] bus_addr;
  logic        bus_paged;
  logic [2:0]  bus_page;
  logic        bus_rd;
  logic        full_mode;
  logic        alt_rw_en;
  logic        alt_rw_val;
  logic        match_q;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  bqc_top i_bqc_top (
    .clk(clk), .rst_n(rst_n), .sys_rst(sys_rst), .dbg_on(dbg_on),
    .trig_start(trig_start), .wr_en(wr_en), .wr_ofs(wr_ofs), .wr_data(wr_data),
    .bus_valid(bus_valid), .bus_addr(bus_addr), .bus_paged(bus_paged),
    .bus_page(bus_page), .bus_rd(bus_rd), .full_mode(full_mode),
    .alt_rw_en(alt_rw_en), .alt_rw_val(alt_rw_val), .match_q(match_q)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input string req, input logic got, input logic exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: match_q=%b expected %b", req, got, exp);
    end
  endtask

  task automatic reg_wr(input logic [3:0] ofs, input logic [7:0] d);
    wr_en = 1'b1; wr_ofs = ofs; wr_data = d;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic set_cmp(input logic [15:0] v);
    reg_wr(4'h4, v[15:8]);
    reg_wr(4'h5, v[7:0]);
  endtask

  // One valid access; match_q is sampled one edge later
  task automatic probe(input string req, input logic [15:0] a, input logic pg,
                       input logic [2:0] pp, input logic rd, input logic fm,
                       input logic ae, input logic av, input logic exp);
    bus_valid = 1'b1; bus_addr = a; bus_paged = pg; bus_page = pp; bus_rd = rd;
    full_mode = fm; alt_rw_en = ae; alt_rw_val = av;
    @(posedge clk); @(negedge clk);
    bus_valid = 1'b0; full_mode = 1'b0; alt_rw_en = 1'b0; alt_rw_val = 1'b0;
    check(req, match_q, exp);
  endtask

  task automatic sreset(input logic d, input logic t);
    sys_rst = 1'b1; dbg_on = d; trig_start = t;
    @(posedge clk); @(negedge clk);
    sys_rst = 1'b0; dbg_on = 1'b0; trig_start = 1'b0;
  endtask

  task automatic t_reset;
    check("R8 reset state", match_q, 1'b0);
    // all-zero configuration: unpaged address 0 matches any direction
    probe("R8 zero config read", 16'h0000, 1'b0, 3'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1);
  endtask

  task automatic t_valid;
    set_cmp(16'h1234);
    bus_valid = 1'b0; bus_addr = 16'h1234; bus_paged = 1'b0; bus_rd = 1'b0;
    @(posedge clk); @(negedge clk);
    check("R1 no valid no pulse", match_q, 1'b0);
    probe("R1 valid pulse", 16'h1234, 1'b0, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
    @(posedge clk); @(negedge clk);
    check("R1 pulse one cycle", match_q, 1'b0);
  endtask

  task automatic t_bytes;
    reg_wr(4'h4, 8'hAB);
    probe("R2 high byte alone", 16'hAB34, 1'b0, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
    probe("R2 old value gone", 16'h1234, 1'b0, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    reg_wr(4'h5, 8'h77);
    probe("R2 low byte alone", 16'hAB77, 1'b0, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
  endtask

  task automatic t_dir;
    set_cmp(16'h4123);
    reg_wr(4'h9, 8'h80);
    probe("R3 write selected, write", 16'h4123, 1'b0, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
    probe("R3 write selected, read", 16'h4123, 1'b0, 3'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    reg_wr(4'h9, 8'hC0);
    probe("R3 read selected, read", 16'h4123, 1'b0, 3'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1);
    probe("R3 read selected, write", 16'h4123, 1'b0, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 0);
    reg_wr(4'h9, 8'h40);
    probe("R3 enable off, write", 16'h4123, 1'b0, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
  endtask

  task automatic t_paged;
    // target 17-bit address {101, 0x0123} -> bit16=1, low16=0x4123
    reg_wr(4'h9, 8'h21);
    probe("R4 paged page 5", 16'hC123, 1'b1, 3'd5, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1);
    probe("R4 not paged", 16'h4123, 1'b0, 3'd5, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    probe("R4 page 4", 16'h4123, 1'b1, 3'd4, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_linear;
    reg_wr(4'h9, 8'h00);
    probe("R5 linear match", 16'h4123, 1'b0, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
    probe("R5 paged refused", 16'h0123, 1'b1, 3'd1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_bit16;
    reg_wr(4'h9, 8'h01);
    probe("R6 bit16=1 unpaged", 16'h4123, 1'b0, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    reg_wr(4'h9, 8'h20);
    probe("R6 bit16=0 page 1", 16'h0123, 1'b1, 3'd1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
    probe("R6 bit16=0 page 5", 16'h0123, 1'b1, 3'd5, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_full;
    reg_wr(4'h9, 8'hA1);
    probe("R7 full, ext ignored", 16'h4123, 1'b0, 3'd0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1);
    probe("R7 full, alt write vs read", 16'h4123, 1'b0, 3'd0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0);
    probe("R7 full, alt read", 16'h4123, 1'b1, 3'd2, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1);
    probe("R7 full, address differs", 16'h4124, 1'b0, 3'd0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_reserved;
    reg_wr(4'h9, 8'h1E);
    probe("R9 bits 4..1 ignored", 16'h4123, 1'b0, 3'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1);
    reg_wr(4'h3, 8'hFF);
    probe("R9 other offset", 16'h4123, 1'b0, 3'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1);
  endtask

  task automatic t_retain;
    reg_wr(4'h9, 8'h80);
    sreset(1'b1, 1'b0);
    probe("R8 kept, read refused", 16'h0000, 1'b0, 3'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    probe("R8 kept, cmp cleared", 16'h0000, 1'b0, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
    sreset(1'b1, 1'b1);
    probe("R8 begin set clears", 16'h0000, 1'b0, 3'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1);
    reg_wr(4'h9, 8'h80);
    sreset(1'b0, 1'b0);
    probe("R8 debug off clears", 16'h0000, 1'b0, 3'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1);
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; sys_rst = 1'b0; dbg_on = 1'b0; trig_start = 1'b0;
    wr_en = 1'b0; wr_ofs = '0; wr_data = '0;
    bus_valid = 1'b0; bus_addr = '0; bus_paged = 1'b0; bus_page = '0; bus_rd = 1'b0;
    full_mode = 1'b0; alt_rw_en = 1'b0; alt_rw_val = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_valid();
    t_bytes();
    t_dir();
    t_paged();
    t_linear();
    t_bit16();
    t_full();
    t_reserved();
    t_retain();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule